// File: doc/BRIEF.md
# Seconds Real-Time Clock Register Block

This block keeps wall-clock time as a 32-bit count of binary seconds and compares it against a 32-bit alarm value. A host reaches it over a simple byte-wide register bus. Every access moves a single byte at an 8-bit address. An internal prescaler divides the system clock down to a one-second tick. Each tick advances the counter by one.

The alarm has no enable bit. It is disarmed by writing all ones into its four bytes, and armed by writing any other value. When a tick carries the counter onto the alarm value, the block sets the alarm bit in the first of three write-one-to-clear event registers. It then holds its interrupt line high until software clears every pending bit. Two control bits select whether the same event also pulses a wake-from-sleep request and a power-up-from-shutdown request. A wake-from-sleep event also sets a force-active bit, which software clears once it has resumed.

The time is read one byte at a time, most significant byte first. Reading the top byte freezes a copy of the whole count, so the later byte reads return bytes that belong together. The time is written the same way, most significant byte first. The last byte written moves the whole staged value into the counter in one step.

Top module: `rtc_seconds`

## Requirements
- R1: A read of address 0x70 returns count bits 31:24 and freezes all 32 count bits into a snapshot. Reads of 0x71, 0x72 and 0x73 return snapshot bits 23:16, 15:8 and 7:0, whatever the counter has done since the snapshot was taken.
- R2: Writes to 0x70, 0x71 and 0x72 stage count bits 31:24, 23:16 and 15:8 without changing the counter. A write to 0x73 loads the staged bits plus the written byte (bits 7:0) into the counter in a single cycle. The same write restarts the prescaler, so the next tick arrives CLK_PER_SEC cycles after the load.
- R3: The counter increments by exactly one on each tick, one tick every CLK_PER_SEC clock cycles, and wraps from 0xFFFFFFFF to 0.
- R4: The alarm value is read and written at 0x74 (bits 31:24), 0x75, 0x76 and 0x77 (bits 7:0). Each byte write takes effect immediately.
- R5: The alarm bit (bit 3 of 0x10) is set only on a tick that carries the counter onto the alarm value. A load that makes the counter equal to the alarm value does not set it. The alarm fires once and does not fire again while the counter runs past the alarm value.
- R6: While the alarm value is 0xFFFFFFFF, no alarm event occurs, including when the counter itself reaches 0xFFFFFFFF.
- R7: Registers 0x10, 0x11 and 0x12 hold event bits, set from `src_evt` bits [7:0], [15:8] and [23:16] respectively. Input bit 3 is ignored, because that position belongs to the alarm. Writing a byte clears the bits where the byte has ones. An event arriving in the same cycle as a clear wins. `irq` is high exactly while any of the 24 bits is set.
- R8: On an alarm event, `wake_sleep` pulses for one cycle, in the cycle after the tick, if bit 3 of 0x29 is set. `wake_pwrup` pulses in the same way if bit 2 of 0x29 is set.
- R9: Bit 2 of 0x28 drives `force_active`. It is set by an alarm event that requests wake from sleep, and cleared when software writes a zero there. Bits 7:0 of 0x28 and 0x29 are read/write storage.
- R10: Address 0x00 reads VENDOR_ID and address 0x01 reads MODEL_REV, which is at least 0x40. Writes to these two addresses change nothing. Reads of unmapped addresses return 0x00. Read data appears on `bus_rdata` in the cycle after `bus_re` and holds until the next read.
- R11: After reset, the counter, the snapshot, the control registers and all event bits are zero, the alarm is 0xFFFFFFFF, and all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| bus_addr | input | 8 | Register byte address |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe, one byte per cycle |
| bus_re | input | 1 | Read strobe, one byte per cycle |
| bus_rdata | output | 8 | Registered read data |
| src_evt | input | 24 | Event pulses for the three event registers (bit 3 unused) |
| irq | output | 1 | High while any event bit is pending |
| wake_sleep | output | 1 | One-cycle wake-from-sleep request |
| wake_pwrup | output | 1 | One-cycle power-up-from-shutdown request |
| force_active | output | 1 | Force-active control bit |

## Verification
The bench reads the snapshot bytes across a counter carry from 0xFF to 0x100. A design that read live count bytes would return a torn value there. It counts the cycles between a time load and the next tick, because a prescaler that is not restarted would tick too early. It also runs the counter through 0xFFFFFFFF with the alarm disarmed, which would fire a spurious alarm if the all-ones value were treated as an ordinary compare value. It clears and sets an event bit in the same cycle, loads a time equal to the armed alarm value, and runs an alarm with both wake enables off. A design that let the clear win, matched on loads, or pulsed wake regardless of the enables would show a wrong event bit or a stray wake pulse.

// File: rtl/rtc_seconds_pkg.sv
package rtc_seconds_pkg;
  typedef logic [7:0] byte_t;

  // Register addresses the host software decodes
  localparam byte_t A_VENDOR     = 8'h00;
  localparam byte_t A_MODREV     = 8'h01;
  localparam byte_t A_SRC_BASE   = 8'h10;
  localparam byte_t A_CTRL_PWR   = 8'h28;
  localparam byte_t A_CTRL_WAKE  = 8'h29;
  localparam byte_t A_TIME_BASE  = 8'h70;
  localparam byte_t A_ALARM_BASE = 8'h74;

  // Bit positions inside those registers
  localparam int ALARM_SRC_BIT  = 3;
  localparam int WAKE_SLEEP_BIT = 3;
  localparam int WAKE_PWRUP_BIT = 2;
  localparam int FORCE_ACT_BIT  = 2;
endpackage

// File: rtl/rtc_seconds_presc.sv
module rtc_seconds_presc #(
  parameter  int DIV = 32768,
  localparam int CW  = (DIV > 1) ? $clog2(DIV) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  output logic          tick,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    tick  = (cnt_q == CW'(DIV - 1));
    cnt_d = cnt_q + 1'b1;
    if (restart || tick) cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/rtc_seconds_timebase.sv
module rtc_seconds_timebase
  import rtc_seconds_pkg::*;
#(
  parameter  int TIME_W = 32,
  localparam int NB     = TIME_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic              rd_en,
  input  byte_t             addr,
  input  byte_t             wdata,
  output logic [TIME_W-1:0] time_o,
  output logic [TIME_W-1:0] alarm_o,
  output logic [TIME_W-1:0] snap_o,
  output logic              load_o,
  output logic              match_o
);
  logic [TIME_W-1:0] time_q, time_d;
  logic [TIME_W-1:0] stage_q, stage_d;
  logic [TIME_W-1:0] snap_q, snap_d;
  logic [TIME_W-1:0] alarm_q, alarm_d;
  logic [TIME_W-1:0] time_inc;

  always_comb begin
    time_inc = time_q + TIME_W'(1);
    load_o   = wr_en && (addr == A_TIME_BASE + 8'(NB - 1));
    time_d   = time_q;
    stage_d  = stage_q;
    alarm_d  = alarm_q;
    snap_d   = snap_q;

    if (load_o)    time_d = {stage_q[TIME_W-1:8], wdata};
    else if (tick) time_d = time_inc;

    if (rd_en && (addr == A_TIME_BASE)) snap_d = time_q;

    // Byte at base+i carries the i-th byte counted from the top
    for (int i = 0; i < NB; i++) begin
      if (wr_en && (addr == A_TIME_BASE + 8'(i)))
        stage_d[(NB-1-i)*8 +: 8] = wdata;
      if (wr_en && (addr == A_ALARM_BASE + 8'(i)))
        alarm_d[(NB-1-i)*8 +: 8] = wdata;
    end

    // All-ones alarm means disarmed; loads never match
    match_o = tick && !load_o && (alarm_q != '1) && (time_inc == alarm_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      time_q  <= '0;
      stage_q <= '0;
      snap_q  <= '0;
      alarm_q <= '1;
    end else begin
      time_q  <= time_d;
      stage_q <= stage_d;
      snap_q  <= snap_d;
      alarm_q <= alarm_d;
    end
  end

  assign time_o  = time_q;
  assign alarm_o = alarm_q;
  assign snap_o  = snap_q;
endmodule

// File: rtl/rtc_seconds_srcflags.sv
module rtc_seconds_srcflags #(
  parameter  int NREG = 3,
  localparam int FW   = NREG * 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [FW-1:0] set_i,
  input  logic [FW-1:0] clr_i,
  output logic [FW-1:0] flags_o,
  output logic          any_o
);
  logic [FW-1:0] flags_q, flags_d;

  // A new event outranks a clear in the same cycle
  always_comb flags_d = (flags_q & ~clr_i) | set_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags_o = flags_q;
  assign any_o   = |flags_q;
endmodule

// File: rtl/rtc_seconds.sv
module rtc_seconds
  import rtc_seconds_pkg::*;
#(
  parameter  int          CLK_PER_SEC = 32768,
  parameter  int          TIME_W      = 32,
  parameter  int          N_SRC       = 3,
  parameter  logic [7:0]  VENDOR_ID   = 8'h5A,
  parameter  logic [7:0]  MODEL_REV   = 8'h41,
  localparam int          SRC_W       = N_SRC * 8,
  localparam int          NB          = TIME_W / 8,
  localparam int          PRESC_W     = (CLK_PER_SEC > 1) ? $clog2(CLK_PER_SEC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [7:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  input  logic             bus_we,
  input  logic             bus_re,
  output logic [7:0]       bus_rdata,
  input  logic [SRC_W-1:0] src_evt,
  output logic             irq,
  output logic             wake_sleep,
  output logic             wake_pwrup,
  output logic             force_active
);
  // Reset: asserted at once, released through two flops
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  logic               tick, time_load, alarm_evt;
  logic [PRESC_W-1:0] presc_q;
  logic [TIME_W-1:0]  time_q, alarm_q, snap_q;
  logic [SRC_W-1:0]   src_set, src_clr, flags_q;
  logic               alarm_flag;

  rtc_seconds_presc #(.DIV(CLK_PER_SEC)) u_presc (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .restart (time_load),
    .tick    (tick),
    .cnt_o   (presc_q)
  );

  rtc_seconds_timebase #(.TIME_W(TIME_W)) u_timebase (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .wr_en   (bus_we),
    .rd_en   (bus_re),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .time_o  (time_q),
    .alarm_o (alarm_q),
    .snap_o  (snap_q),
    .load_o  (time_load),
    .match_o (alarm_evt)
  );

  always_comb begin
    src_set                = src_evt;
    src_set[ALARM_SRC_BIT] = alarm_evt;
    src_clr                = '0;
    for (int r = 0; r < N_SRC; r++)
      if (bus_we && (bus_addr == A_SRC_BASE + 8'(r)))
        src_clr[r*8 +: 8] = bus_wdata;
  end

  rtc_seconds_srcflags #(.NREG(N_SRC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .set_i   (src_set),
    .clr_i   (src_clr),
    .flags_o (flags_q),
    .any_o   (irq)
  );
  assign alarm_flag = flags_q[ALARM_SRC_BIT];

  // Control registers and wake pulses
  byte_t ctl_pwr_q, ctl_pwr_d, ctl_wake_q, ctl_wake_d;
  logic  ws_q, ws_d, wp_q, wp_d;

  always_comb begin
    ctl_pwr_d  = ctl_pwr_q;
    ctl_wake_d = ctl_wake_q;
    if (bus_we && (bus_addr == A_CTRL_PWR))  ctl_pwr_d  = bus_wdata;
    if (bus_we && (bus_addr == A_CTRL_WAKE)) ctl_wake_d = bus_wdata;
    ws_d = alarm_evt && ctl_wake_q[WAKE_SLEEP_BIT];
    wp_d = alarm_evt && ctl_wake_q[WAKE_PWRUP_BIT];
    if (ws_d) ctl_pwr_d[FORCE_ACT_BIT] = 1'b1;
  end

  // Read path
  byte_t rd_val, rdata_q, rdata_d;

  always_comb begin
    rd_val = '0;
    if (bus_addr == A_VENDOR)    rd_val = VENDOR_ID;
    if (bus_addr == A_MODREV)    rd_val = MODEL_REV;
    if (bus_addr == A_CTRL_PWR)  rd_val = ctl_pwr_q;
    if (bus_addr == A_CTRL_WAKE) rd_val = ctl_wake_q;
    for (int r = 0; r < N_SRC; r++)
      if (bus_addr == A_SRC_BASE + 8'(r)) rd_val = flags_q[r*8 +: 8];
    for (int i = 0; i < NB; i++) begin
      if (bus_addr == A_TIME_BASE + 8'(i))
        rd_val = (i == 0) ? time_q[TIME_W-1 -: 8] : snap_q[(NB-1-i)*8 +: 8];
      if (bus_addr == A_ALARM_BASE + 8'(i))
        rd_val = alarm_q[(NB-1-i)*8 +: 8];
    end
    rdata_d = bus_re ? rd_val : rdata_q;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctl_pwr_q  <= '0;
      ctl_wake_q <= '0;
      ws_q       <= 1'b0;
      wp_q       <= 1'b0;
      rdata_q    <= '0;
    end else begin
      ctl_pwr_q  <= ctl_pwr_d;
      ctl_wake_q <= ctl_wake_d;
      ws_q       <= ws_d;
      wp_q       <= wp_d;
      rdata_q    <= rdata_d;
    end
  end

  assign bus_rdata    = rdata_q;
  assign wake_sleep   = ws_q;
  assign wake_pwrup   = wp_q;
  assign force_active = ctl_pwr_q[FORCE_ACT_BIT];
endmodule

// File: rtl/rtc_seconds_chk.sv
module rtc_seconds_chk #(
  parameter int TIME_W = 32,
  parameter int PW     = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wake_sleep,
  input logic              wake_pwrup,
  input logic              force_active,
  input logic              alarm_flag,
  input logic              load,
  input logic [PW-1:0]     presc,
  input logic [TIME_W-1:0] time_q,
  input logic [TIME_W-1:0] alarm_q
);
  // R8
  wake_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sleep |=> !wake_sleep);

  // R8
  wake_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_sleep || wake_pwrup) |-> alarm_flag);

  // R9
  force_on_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_sleep |-> force_active);

  // R6
  disarmed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> ($past(alarm_q) != '1));

  // R5
  match_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> (time_q == $past(alarm_q)));

  // R3
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(load) && (time_q != $past(time_q))) |-> (time_q == $past(time_q) + TIME_W'(1)));

  // R2
  presc_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(load) |-> (presc == '0));
endmodule

bind rtc_seconds rtc_seconds_chk #(.TIME_W(TIME_W), .PW(PRESC_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .wake_sleep   (wake_sleep),
  .wake_pwrup   (wake_pwrup),
  .force_active (force_active),
  .alarm_flag   (alarm_flag),
  .load         (time_load),
  .presc        (presc_q),
  .time_q       (time_q),
  .alarm_q      (alarm_q)
);

// File: tb/rtc_seconds_bench.sv
module rtc_seconds_bench;
  localparam int DIV = 8;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  b_addr, b_wd, bus_rdata;
  logic        b_we, b_re;
  logic [23:0] b_src;
  logic        irq, wake_sleep, wake_pwrup, force_active;

  always #10 clk = ~clk;

  rtc_seconds #(.CLK_PER_SEC(DIV)) u_rtc_seconds (
    .clk(clk), .rst_n(rst_n), .bus_addr(b_addr), .bus_wdata(b_wd),
    .bus_we(b_we), .bus_re(b_re), .bus_rdata(bus_rdata), .src_evt(b_src),
    .irq(irq), .wake_sleep(wake_sleep), .wake_pwrup(wake_pwrup),
    .force_active(force_active)
  );

  int    n_chk = 0, n_fail = 0, rel = 0, ws_cnt = 0, wp_cnt = 0;
  string cur_req = "R11";

  // Behavioural reference model
  logic [31:0] m_time, m_alarm, m_stage, m_snap;
  int          m_presc;
  logic [7:0]  m_src [3];
  logic [7:0]  m_pwr, m_wake, m_rdata;
  logic        m_ws, m_wp;

  function automatic logic [7:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return 8'h5A;
      8'h01: return 8'h41;
      8'h10: return m_src[0];
      8'h11: return m_src[1];
      8'h12: return m_src[2];
      8'h28: return m_pwr;
      8'h29: return m_wake;
      8'h70: return m_time[31:24];
      8'h71: return m_snap[23:16];
      8'h72: return m_snap[15:8];
      8'h73: return m_snap[7:0];
      8'h74: return m_alarm[31:24];
      8'h75: return m_alarm[23:16];
      8'h76: return m_alarm[15:8];
      8'h77: return m_alarm[7:0];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) rel = 0;
    else if (rel < 3) rel++;
    if (rel < 3) begin
      m_time = 0; m_alarm = 32'hFFFFFFFF; m_stage = 0; m_snap = 0; m_presc = 0;
      for (int r = 0; r < 3; r++) m_src[r] = 0;
      m_pwr = 0; m_wake = 0; m_rdata = 0; m_ws = 0; m_wp = 0;
    end else begin : step
      logic       tk, ld, ev;
      logic [7:0] rv, ext;
      tk = (m_presc == DIV - 1);
      ld = b_we && (b_addr == 8'h73);
      rv = model_read(b_addr);
      ev = tk && !ld && (m_alarm != 32'hFFFFFFFF) && ((m_time + 32'd1) == m_alarm);
      if (b_re) begin
        m_rdata = rv;
        if (b_addr == 8'h70) m_snap = m_time;
      end
      for (int r = 0; r < 3; r++) begin
        ext = b_src[r*8 +: 8];
        if (r == 0) ext[3] = 1'b0;
        if (b_we && (b_addr == 8'h10 + 8'(r))) m_src[r] = m_src[r] & ~b_wd;
        m_src[r] = m_src[r] | ext;
      end
      if (ev) m_src[0][3] = 1'b1;
      m_ws = ev && m_wake[3];
      m_wp = ev && m_wake[2];
      if (b_we && b_addr == 8'h28) m_pwr = b_wd;
      if (m_ws) m_pwr[2] = 1'b1;
      if (b_we && b_addr == 8'h29) m_wake = b_wd;
      if (b_we && b_addr >= 8'h74 && b_addr <= 8'h77)
        m_alarm[(3 - (b_addr - 8'h74))*8 +: 8] = b_wd;
      if (ld) m_time = {m_stage[31:8], b_wd};
      else if (tk) m_time = m_time + 32'd1;
      if (b_we && b_addr >= 8'h70 && b_addr <= 8'h72)
        m_stage[(3 - (b_addr - 8'h70))*8 +: 8] = b_wd;
      m_presc = (ld || tk) ? 0 : m_presc + 1;
    end
  end

  // Cycle-by-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (wake_sleep) ws_cnt++;
    if (wake_pwrup) wp_cnt++;
    if (rel >= 3) begin
      n_chk++;
      if (bus_rdata !== m_rdata || irq !== ((m_src[0] | m_src[1] | m_src[2]) != 0) ||
          wake_sleep !== m_ws || wake_pwrup !== m_wp || force_active !== m_pwr[2]) begin
        n_fail++;
        $display("FAIL %s per-cycle: rdata/irq/ws/wp/fa actual %h %b %b %b %b expected %h %b %b %b %b",
                 cur_req, bus_rdata, irq, wake_sleep, wake_pwrup, force_active,
                 m_rdata, ((m_src[0] | m_src[1] | m_src[2]) != 0), m_ws, m_wp, m_pwr[2]);
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    b_addr = a; b_wd = d; b_we = 1'b1;
    @(negedge clk);
    b_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [7:0] a, input logic [7:0] exp);
    b_addr = a; b_re = 1'b1;
    @(negedge clk);
    b_re = 1'b0;
    chk(req, {24'h0, bus_rdata}, {24'h0, exp});
  endtask

  task automatic wr_time(input logic [31:0] t);
    wr(8'h70, t[31:24]); wr(8'h71, t[23:16]); wr(8'h72, t[15:8]); wr(8'h73, t[7:0]);
  endtask

  task automatic wr_alarm(input logic [31:0] t);
    wr(8'h74, t[31:24]); wr(8'h75, t[23:16]); wr(8'h76, t[15:8]); wr(8'h77, t[7:0]);
  endtask

  task automatic finish_run();
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; b_we = 0; b_re = 0; b_addr = 0; b_wd = 0; b_src = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 reset state
    cur_req = "R11";
    rd_chk("R11", 8'h28, 8'h00);
    rd_chk("R11", 8'h29, 8'h00);
    rd_chk("R11", 8'h10, 8'h00);
    rd_chk("R11", 8'h77, 8'hFF);
    chk("R11", {31'h0, irq}, 32'h0);
    chk("R11", {31'h0, force_active}, 32'h0);

    // R10 identification, read-only, unmapped
    cur_req = "R10";
    rd_chk("R10", 8'h00, 8'h5A);
    wr(8'h00, 8'h12);
    rd_chk("R10", 8'h00, 8'h5A);
    rd_chk("R10", 8'h01, 8'h41);
    rd_chk("R10", 8'h55, 8'h00);
    rd_chk("R10", 8'h2A, 8'h00);

    // R2 staged load restarts the prescaler
    cur_req = "R2";
    wr_time(32'h10);
    repeat (7) @(negedge clk);
    rd_chk("R2", 8'h70, 8'h00);
    rd_chk("R2", 8'h73, 8'h10);
    rd_chk("R2", 8'h70, 8'h00);
    rd_chk("R2", 8'h73, 8'h11);

    // R1 snapshot coherence across a byte carry
    cur_req = "R1";
    wr_time(32'hFF);
    rd_chk("R1", 8'h70, 8'h00);
    repeat (20) @(negedge clk);
    rd_chk("R1", 8'h73, 8'hFF);
    rd_chk("R1", 8'h72, 8'h00);
    rd_chk("R1", 8'h71, 8'h00);
    rd_chk("R1", 8'h70, 8'h00);
    rd_chk("R1", 8'h72, 8'h01);

    // R4 R5 R8 R9 alarm with both wake enables
    cur_req = "R5";
    wr(8'h29, 8'h0C);
    wr_time(32'h100);
    wr_alarm(32'h103);
    rd_chk("R4", 8'h76, 8'h01);
    rd_chk("R4", 8'h77, 8'h03);
    ws_cnt = 0; wp_cnt = 0;
    repeat (30) @(negedge clk);
    chk("R7", {31'h0, irq}, 32'h1);
    chk("R8", ws_cnt, 1);
    chk("R8", wp_cnt, 1);
    chk("R9", {31'h0, force_active}, 32'h1);
    rd_chk("R5", 8'h10, 8'h08);
    wr(8'h10, 8'h08);
    rd_chk("R7", 8'h10, 8'h00);
    repeat (3 * DIV + 2) @(negedge clk);
    rd_chk("R5", 8'h10, 8'h00);
    chk("R5", {31'h0, irq}, 32'h0);
    cur_req = "R9";
    wr(8'h28, 8'h00);
    chk("R9", {31'h0, force_active}, 32'h0);

    // R6 R3 disarmed alarm while the counter wraps
    cur_req = "R6";
    wr_alarm(32'hFFFFFFFF);
    wr_time(32'hFFFFFFFE);
    repeat (20) @(negedge clk);
    rd_chk("R3", 8'h70, 8'h00);
    rd_chk("R3", 8'h73, 8'h00);
    rd_chk("R6", 8'h10, 8'h00);
    chk("R6", ws_cnt, 1);

    // R7 event registers
    cur_req = "R7";
    b_src = 24'h800102;
    @(negedge clk);
    b_src = 24'h0;
    chk("R7", {31'h0, irq}, 32'h1);
    rd_chk("R7", 8'h10, 8'h02);
    rd_chk("R7", 8'h11, 8'h01);
    rd_chk("R7", 8'h12, 8'h80);
    wr(8'h11, 8'h01);
    rd_chk("R7", 8'h11, 8'h00);
    chk("R7", {31'h0, irq}, 32'h1);
    b_src = 24'h800000; b_addr = 8'h12; b_wd = 8'h80; b_we = 1'b1;
    @(negedge clk);
    b_src = 24'h0; b_we = 1'b0;
    rd_chk("R7", 8'h12, 8'h80);
    wr(8'h12, 8'h80);
    wr(8'h10, 8'h02);
    chk("R7", {31'h0, irq}, 32'h0);
    b_src = 24'h000008;
    @(negedge clk);
    b_src = 24'h0;
    rd_chk("R7", 8'h10, 8'h00);
    chk("R7", {31'h0, irq}, 32'h0);

    // R5 load onto alarm value, R8 wake gated off
    cur_req = "R5";
    wr(8'h29, 8'h00);
    wr_alarm(32'h200);
    wr_time(32'h200);
    repeat (3) @(negedge clk);
    rd_chk("R5", 8'h10, 8'h00);
    wr(8'h77, 8'h02);
    cur_req = "R8";
    repeat (20) @(negedge clk);
    rd_chk("R5", 8'h10, 8'h08);
    chk("R8", ws_cnt, 1);
    chk("R8", wp_cnt, 1);
    chk("R9", {31'h0, force_active}, 32'h0);
    wr(8'h10, 8'h08);
    repeat (2) @(negedge clk);

    finish_run();
  end
endmodule